// File: doc/BRIEF.md
# Set-Associative Cache Tag Tracker

This block models only the bookkeeping side of a cache: tags, valid bits, dirty bits and replacement order. It keeps no data. It takes a stream of addresses, each tagged as a read or a write. For each one it reports what the cache would do: whether the access hit, which way of the set it used, and what that way held beforehand. On a miss it also reports whether a resident line was pushed out and whether that line had to be written back to memory. It is meant for trace generation and for checking the cache behaviour of a larger design.

The organisation is set by parameters: the total block count, the number of words per block and the associativity. With one way the cache is direct-mapped. With as many ways as blocks it is fully associative. Replacement is either least-recently-used or first-in-first-out. The write policy is either write-back or write-through.

The input side is always ready, so a new access can be taken every cycle. Its result is registered and appears on the following cycle.

Top module: `cache_tag_tracker`

## Requirements
- R1: `req_ready` is always 1. A request taken with `req_valid` high at a clock edge gives `rsp_valid` high after that edge. A cycle without a request gives `rsp_valid` low after the edge.
- R2: The address is split from the least significant bit upward. The low log2(WORDS_PER_BLOCK) bits are the offset. The next log2(NUM_BLOCKS/WAYS) bits select the set. The remaining upper bits are the tag. Two addresses that differ only in the offset reach the same line.
- R3: An access hits when a valid way of its set holds its tag. `rsp_hit` is then 1 and `rsp_way` names that way.
- R4: A miss in a set that still has invalid ways fills the lowest-numbered invalid way.
- R5: With LRU selected, a miss in a full set replaces the way whose last hit or fill lies furthest back.
- R6: With FIFO selected, a miss in a full set replaces the way filled earliest. Hits do not change this order.
- R7: `rsp_prev_valid` and `rsp_prev_tag` give the valid bit and the tag of the chosen way as they were before the access.
- R8: `rsp_purge` is 1 exactly when a miss replaces a valid line.
- R9: Under write-back, a write (hit or allocating miss) marks the line dirty, and a read miss installs a clean line. `rsp_writeback` is 1 exactly when a dirty line is replaced.
- R10: Under write-through, no line ever becomes dirty and `rsp_writeback` stays 0.
- R11: Synchronous reset invalidates every line, clears all dirty and order state, and drops `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | An access is offered |
| req_ready | output | 1 | Access accepted (constant 1) |
| req_addr | input | ADDR_W | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Result present for the previous cycle's access |
| rsp_hit | output | 1 | Access hit |
| rsp_way | output | WAY_W | Way used within the set |
| rsp_prev_valid | output | 1 | Chosen way was valid before the access |
| rsp_prev_tag | output | TAG_W | Chosen way's tag before the access |
| rsp_purge | output | 1 | A valid line was replaced |
| rsp_writeback | output | 1 | The replaced line was dirty |

## Verification
The bench runs four instances side by side: 2-way LRU write-back, fully associative LRU, 4-way FIFO write-through, and direct-mapped. All four see the same address stream, and each is compared against a model based on timestamps.

The directed cases target five corner cases:
- Filling a set with holes: a design that ignored the lowest-free rule would fill the wrong way.
- A hit between two fills: an LRU design that did not update order on a hit would pick the wrong victim, and a FIFO design that did update on a hit would also pick the wrong one.
- Replacing a line that was written: a design that lost the dirty bit would miss the write-back flag.
- Writes under write-through: a design that set the dirty bit here would raise a write-back flag that should never appear.
- Reset with lines resident: stale valid bits would show up as false hits afterwards.

// File: rtl/cache_tag_tracker.sv
`timescale 1ns/1ps
module cache_tag_tracker #(
  parameter int ADDR_W = 8,
  parameter int NUM_BLOCKS = 8,
  parameter int WORDS_PER_BLOCK = 2,
  parameter int WAYS = 2,
  parameter bit USE_FIFO = 1'b0,
  parameter bit WRITE_THROUGH = 1'b0,
  localparam int SETS = NUM_BLOCKS / WAYS,
  localparam int OFF_W = $clog2(WORDS_PER_BLOCK),
  localparam int IDX_W = $clog2(SETS),
  localparam int IDX_WS = (IDX_W > 0) ? IDX_W : 1,
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic              rsp_prev_valid,
  output logic [TAG_W-1:0]  rsp_prev_tag,
  output logic              rsp_purge,
  output logic              rsp_writeback
);

  logic [TAG_W-1:0] tag_q  [SETS][WAYS];
  logic [WAY_W-1:0] rank_q [SETS][WAYS];
  logic             vld_q  [SETS][WAYS];
  logic             dty_q  [SETS][WAYS];

  logic [IDX_WS-1:0] set_i;
  logic [TAG_W-1:0]  tag_i;
  logic              hit, has_free, touch;
  logic [WAY_W-1:0]  hit_w, free_w, old_w, way;

  assign req_ready = 1'b1;
  assign tag_i = req_addr[ADDR_W-1 -: TAG_W];
  assign set_i = (IDX_W == 0) ? '0 : IDX_WS'(req_addr >> OFF_W);
  assign touch = !hit || !USE_FIFO;

  always_comb begin
    hit = 1'b0;
    hit_w = '0;
    has_free = 1'b0;
    free_w = '0;
    old_w = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_q[set_i][w]) begin
        has_free = 1'b1;
        free_w = WAY_W'(w);
      end
      if (vld_q[set_i][w] && tag_q[set_i][w] == tag_i) begin
        hit = 1'b1;
        hit_w = WAY_W'(w);
      end
      if (rank_q[set_i][w] == WAY_W'(WAYS - 1)) old_w = WAY_W'(w);
    end
    way = hit ? hit_w : (has_free ? free_w : old_w);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit <= 1'b0;
      rsp_way <= '0;
      rsp_prev_valid <= 1'b0;
      rsp_prev_tag <= '0;
      rsp_purge <= 1'b0;
      rsp_writeback <= 1'b0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          vld_q[s][w] <= 1'b0;
          dty_q[s][w] <= 1'b0;
          rank_q[s][w] <= '0;
        end
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit <= hit;
        rsp_way <= way;
        rsp_prev_valid <= vld_q[set_i][way];
        rsp_prev_tag <= tag_q[set_i][way];
        rsp_purge <= !hit && !has_free;
        rsp_writeback <= !hit && !has_free && dty_q[set_i][way] && !WRITE_THROUGH;
        if (!hit) begin
          tag_q[set_i][way] <= tag_i;
          vld_q[set_i][way] <= 1'b1;
          dty_q[set_i][way] <= req_write && !WRITE_THROUGH;
        end else if (req_write && !WRITE_THROUGH) begin
          dty_q[set_i][way] <= 1'b1;
        end
        if (touch) begin
          for (int w = 0; w < WAYS; w++)
            if (WAY_W'(w) != way && vld_q[set_i][w] &&
                (!vld_q[set_i][way] || rank_q[set_i][w] < rank_q[set_i][way]))
              rank_q[set_i][w] <= rank_q[set_i][w] + 1'b1;
          rank_q[set_i][way] <= '0;
        end
      end
    end
  end

endmodule

module cache_tag_tracker_chk #(
  parameter int ADDR_W = 8,
  parameter int TAG_W = 5,
  parameter int WAY_W = 1,
  parameter bit WRITE_THROUGH = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [WAY_W-1:0]  rsp_way,
  input logic              rsp_prev_valid,
  input logic [TAG_W-1:0]  rsp_prev_tag,
  input logic              rsp_purge,
  input logic              rsp_writeback
);

  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> rsp_valid);

  // R1
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R7
  hit_prev_tag_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !rsp_hit || (rsp_prev_valid && rsp_prev_tag == $past(req_addr[ADDR_W-1 -: TAG_W])));

  // R8
  purge_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_purge |-> !rsp_hit && rsp_prev_valid);

  // R9
  wb_needs_purge_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_writeback |-> rsp_purge);

  // R10
  wt_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_writeback |-> !WRITE_THROUGH);

  // R11
  reset_drops_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !rsp_valid);

endmodule

bind cache_tag_tracker cache_tag_tracker_chk #(
  .ADDR_W(ADDR_W), .TAG_W(TAG_W), .WAY_W(WAY_W), .WRITE_THROUGH(WRITE_THROUGH)
) u_chk (.*);

// File: tb/cache_tag_tracker_bench.sv
`timescale 1ns/1ps
module cache_tag_tracker_bench;
  localparam int NC = 4;
  localparam int CW [NC] = '{2, 8, 4, 1};
  localparam int CO [NC] = '{1, 1, 2, 0};
  localparam int CF [NC] = '{0, 0, 1, 0};
  localparam int CT [NC] = '{0, 0, 1, 0};

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  always #2.5 clk = ~clk;

  logic o_rdy [NC], o_v [NC], o_hit [NC], o_pv [NC], o_pg [NC], o_wb [NC];
  logic [7:0] o_way [NC], o_tag [NC];
  logic [0:0] w0, w3;
  logic [2:0] w1;
  logic [1:0] w2;
  logic [4:0] t0, t2, t3;
  logic [6:0] t1;
  assign o_way[0] = 8'(w0); assign o_way[1] = 8'(w1);
  assign o_way[2] = 8'(w2); assign o_way[3] = 8'(w3);
  assign o_tag[0] = 8'(t0); assign o_tag[1] = 8'(t1);
  assign o_tag[2] = 8'(t2); assign o_tag[3] = 8'(t3);

  cache_tag_tracker u_cache_tag_tracker (.clk, .rst, .req_valid, .req_ready(o_rdy[0]),
    .req_addr, .req_write, .rsp_valid(o_v[0]), .rsp_hit(o_hit[0]), .rsp_way(w0),
    .rsp_prev_valid(o_pv[0]), .rsp_prev_tag(t0), .rsp_purge(o_pg[0]), .rsp_writeback(o_wb[0]));
  cache_tag_tracker #(.WAYS(8)) u_cache_tag_tracker_fa (.clk, .rst, .req_valid,
    .req_ready(o_rdy[1]), .req_addr, .req_write, .rsp_valid(o_v[1]), .rsp_hit(o_hit[1]),
    .rsp_way(w1), .rsp_prev_valid(o_pv[1]), .rsp_prev_tag(t1), .rsp_purge(o_pg[1]),
    .rsp_writeback(o_wb[1]));
  cache_tag_tracker #(.WAYS(4), .WORDS_PER_BLOCK(4), .USE_FIFO(1'b1), .WRITE_THROUGH(1'b1))
    u_cache_tag_tracker_ff (.clk, .rst, .req_valid, .req_ready(o_rdy[2]), .req_addr,
    .req_write, .rsp_valid(o_v[2]), .rsp_hit(o_hit[2]), .rsp_way(w2),
    .rsp_prev_valid(o_pv[2]), .rsp_prev_tag(t2), .rsp_purge(o_pg[2]), .rsp_writeback(o_wb[2]));
  cache_tag_tracker #(.WAYS(1), .WORDS_PER_BLOCK(1)) u_cache_tag_tracker_dm (.clk, .rst,
    .req_valid, .req_ready(o_rdy[3]), .req_addr, .req_write, .rsp_valid(o_v[3]),
    .rsp_hit(o_hit[3]), .rsp_way(w3), .rsp_prev_valid(o_pv[3]), .rsp_prev_tag(t3),
    .rsp_purge(o_pg[3]), .rsp_writeback(o_wb[3]));

  bit m_vld [NC][8][8];
  bit m_dty [NC][8][8];
  int m_tag [NC][8][8];
  int m_st  [NC][8][8];
  int stamp = 0;
  int e_hit [NC], e_way [NC], e_pv [NC], e_tag [NC], e_pg [NC], e_wb [NC];
  string e_why [NC];
  int checks = 0, fails = 0;

  task automatic model_clear();
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < 8; s++)
        for (int w = 0; w < 8; w++) begin
          m_vld[c][s][w] = 0; m_dty[c][s][w] = 0; m_st[c][s][w] = 0;
        end
  endtask

  task automatic model(input int c, input int addr, input bit wr);
    int sets, idx, tag, way, oldest;
    bit hit, free;
    sets = 8 / CW[c];
    idx = (addr >> CO[c]) % sets;
    tag = addr >> (CO[c] + $clog2(sets));
    hit = 0; free = 0; way = 0; oldest = 0;
    stamp++;
    for (int w = 0; w < CW[c]; w++)
      if (m_vld[c][idx][w] && m_tag[c][idx][w] == tag) begin hit = 1; way = w; end
    if (!hit)
      for (int w = CW[c] - 1; w >= 0; w--)
        if (!m_vld[c][idx][w]) begin free = 1; way = w; end
    if (!hit && !free) begin
      for (int w = 1; w < CW[c]; w++)
        if (m_st[c][idx][w] < m_st[c][idx][oldest]) oldest = w;
      way = oldest;
    end
    e_hit[c] = hit; e_way[c] = way;
    e_pv[c] = m_vld[c][idx][way]; e_tag[c] = m_tag[c][idx][way];
    e_pg[c] = !hit && !free;
    e_wb[c] = !hit && !free && m_dty[c][idx][way] && !CT[c];
    e_why[c] = hit ? "R3" : (free ? "R4" : (CF[c] != 0 ? "R6" : "R5"));
    if (hit) begin
      if (wr && !CT[c]) m_dty[c][idx][way] = 1;
      if (!CF[c]) m_st[c][idx][way] = stamp;
    end else begin
      m_vld[c][idx][way] = 1; m_tag[c][idx][way] = tag;
      m_dty[c][idx][way] = wr && !CT[c]; m_st[c][idx][way] = stamp;
    end
  endtask

  task automatic chk(input string req, input int c, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cfg%0d %s: actual %0d expected %0d", req, c, what, act, exp);
    end
  endtask

  task automatic acc(input int addr, input bit wr, input string hitreq = "R3");
    req_valid = 1; req_addr = 8'(addr); req_write = wr;
    for (int c = 0; c < NC; c++) model(c, addr, wr);
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      chk("R1", c, "rsp_valid", int'(o_v[c]), 1);
      chk(hitreq, c, "hit", int'(o_hit[c]), e_hit[c]);
      chk(e_why[c], c, "way", int'(o_way[c]), e_way[c]);
      chk("R7", c, "prev_valid", int'(o_pv[c]), e_pv[c]);
      if (e_pv[c] != 0) chk("R7", c, "prev_tag", int'(o_tag[c]), e_tag[c]);
      chk("R8", c, "purge", int'(o_pg[c]), e_pg[c]);
      chk(CT[c] != 0 ? "R10" : "R9", c, "writeback", int'(o_wb[c]), e_wb[c]);
    end
  endtask

  task automatic idle();
    req_valid = 0;
    @(negedge clk);
    for (int c = 0; c < NC; c++) chk("R1", c, "idle rsp_valid", int'(o_v[c]), 0);
  endtask

  task automatic do_reset();
    req_valid = 0; rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0; model_clear();
    for (int c = 0; c < NC; c++) begin
      chk("R11", c, "reset rsp_valid", int'(o_v[c]), 0);
      chk("R1", c, "ready", int'(o_rdy[c]), 1);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'd2718));
    do_reset();
    acc(8'hE3, 0); acc(8'hE1, 1); acc(8'hE2, 1); acc(8'hAD, 1); acc(8'hC2, 0);
    acc(8'hE2, 0); acc(8'hC0, 1); acc(8'h93, 0); acc(8'h82, 0); acc(8'hE0, 0);
    acc(8'hE2, 0); acc(8'h8A, 1); acc(8'hAA, 1); acc(8'h88, 0);
    idle();
    // R2: same block, different offset
    do_reset();
    acc(8'h40, 0); acc(8'h41, 0, "R2");
    // R4, R9: holes filled lowest first, dirty eviction under write-back
    do_reset();
    for (int i = 0; i < 10; i++) acc(i * 8, 1);
    // R5, R6: hit between fills decides victim
    do_reset();
    acc(8'h00, 0); acc(8'h08, 0); acc(8'h00, 0); acc(8'h10, 0);
    acc(8'h18, 0); acc(8'h20, 0); acc(8'h00, 0); acc(8'h28, 0);
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 10 == 0) idle();
      else acc(int'($urandom & 32'h9F), 1'($urandom % 2));
    end
    // R11: reset drops lines that were resident
    acc(8'h50, 0);
    do_reset();
    acc(8'h50, 0, "R11");
    idle();
    report();
  end
endmodule